// File: doc/BRIEF.md
# Half-Symbol-Spaced Adaptive PAM-8 Equalizer

This block is the digital receive equalizer for one wire pair of an eight-level pulse-amplitude link. Converter samples arrive two per symbol period. They shift into a tapped delay line whose taps sit half a symbol apart. Once per symbol, on every second accepted sample, the block forms one filter output, slices it to the nearest of eight evenly spaced levels, and reports both the soft value and the hard symbol.

The tap weights adapt by a sign-preserving gradient least-mean-squares step. The error is measured against an externally supplied symbol while training is enabled. Otherwise it is measured against the slicer's own decision. The step size is a power of two picked by a small select input. Weights, the output and the error all saturate at fixed widths.

The block does not recover timing or control gain. It expects the sample strobe to already carry two samples per symbol, at full scale.

Top module: `fse_lms_equalizer`

## Requirements
- R1: After reset, `out_valid` is 0, `eq_out` is 0 and `dec_sym` is 0. The weight at the middle tap (index NTAPS/2, which is 12 by default) starts at unity, equal to 2^(CW-2) (256 by default), and every other weight starts at 0.
- R2: Every second accepted sample produces exactly one result. Samples are counted from reset, and a sample is accepted on a clock edge where `smp_valid` is 1. `out_valid` is 1 for the single cycle after the first edge that follows the accepting edge. `eq_out` and `dec_sym` hold their values while `out_valid` is 0. Cycles with `smp_valid` at 0 change no state.
- R3: The filter window has NTAPS taps (25 by default). Tap w[0] is the sample accepted on the completing edge, and w[k] is the sample accepted k samples earlier, or 0 if there is none. `eq_out` is sum(c[k]*w[k]) shifted right arithmetically by CW-2 (floor), then saturated to a signed AW-bit value (AW = 12).
- R4: `dec_sym` = clamp(floor((eq_out + 64) / 16), 0, 7). Symbol s stands for the level 16*s - 56 in sample units.
- R5: While training, `ref_sym`, `train_en` and `mu_sel` are taken only from the completing sample. The error is e = sat_AW(level(`ref_sym`) - `eq_out`). Their values on other samples and on idle cycles have no effect.
- R6: When `train_en` is 0 on the completing sample, the error is e = sat_AW(level(`dec_sym`) - `eq_out`), where `dec_sym` is the decision produced for that same symbol.
- R7: After each result, every weight becomes c[k] + floor(e*w[k] / 2^(6+`mu_sel`)). The new weights first apply to the next symbol.
- R8: Weights saturate to the signed CW-bit range, which is -512 to 511 by default.
- R9: `eq_out` saturates at 2047 and -2048. The slicer then clamps to symbol 7 or symbol 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_in | input | XW (7) | Signed converter sample |
| smp_valid | input | 1 | Sample strobe |
| ref_sym | input | 3 | Known symbol used while training |
| train_en | input | 1 | 1 selects reference-driven error, 0 selects decision-driven error |
| mu_sel | input | MUW (2) | Step-size select; the shift is 6 + mu_sel |
| eq_out | output | AW (12) | Signed equalized value |
| dec_sym | output | 3 | Sliced symbol |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
A weight that is wrong by even one step changes `eq_out` on the first result whose window holds a nonzero sample at that tap. Because the error feeds every later update, the damage then spreads to all taps within a few symbols. A slipped half-symbol phase shows at once, since every window is offset by one sample against the scoreboard's model. A bad shift or a missing saturation only shows once a large error or a long run of full-scale samples reaches it. For that reason the bench drives the weights into both rails on purpose.

// File: rtl/fse_eq_pkg.sv
package fse_eq_pkg;
  localparam int PAM_BITS   = 3;
  localparam int PAM_LEVELS = 1 << PAM_BITS;
  typedef logic [PAM_BITS-1:0] pam_sym_t;
endpackage

// File: rtl/fse_eq_tapline.sv
// Half-symbol delay line with symbol phase and per-symbol window snapshot.
module fse_eq_tapline
  import fse_eq_pkg::*;
#(
  parameter int NTAPS = 25,
  parameter int XW    = 7,
  parameter int MUW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] smp_in,
  input  logic                 smp_valid,
  input  pam_sym_t             ref_sym,
  input  logic                 train_en,
  input  logic [MUW-1:0]       mu_sel,
  output logic signed [XW-1:0] win_q [NTAPS],
  output pam_sym_t             ref_q,
  output logic                 train_q,
  output logic [MUW-1:0]       mu_q,
  output logic                 fire_q
);
  logic signed [XW-1:0] hist_q [NTAPS-1];
  logic signed [XW-1:0] hist_d [NTAPS-1];
  logic signed [XW-1:0] cur    [NTAPS];
  logic signed [XW-1:0] win_d  [NTAPS];
  logic                 phase_q, phase_d;
  logic                 fire_d, train_d;
  pam_sym_t             ref_d;
  logic [MUW-1:0]       mu_d;

  assign cur[0] = smp_in;
  for (genvar k = 1; k < NTAPS; k++) begin : g_win
    assign cur[k] = hist_q[k-1];
  end

  always_comb begin
    hist_d  = hist_q;
    win_d   = win_q;
    phase_d = phase_q;
    ref_d   = ref_q;
    train_d = train_q;
    mu_d    = mu_q;
    fire_d  = 1'b0;
    if (smp_valid) begin
      for (int k = 0; k < NTAPS-1; k++) hist_d[k] = cur[k];
      phase_d = ~phase_q;
      if (phase_q) begin
        win_d   = cur;
        ref_d   = ref_sym;
        train_d = train_en;
        mu_d    = mu_sel;
        fire_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS-1; k++) hist_q[k] <= '0;
      for (int k = 0; k < NTAPS; k++)   win_q[k]  <= '0;
      phase_q <= 1'b0;
      ref_q   <= '0;
      train_q <= 1'b0;
      mu_q    <= '0;
      fire_q  <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      win_q   <= win_d;
      phase_q <= phase_d;
      ref_q   <= ref_d;
      train_q <= train_d;
      mu_q    <= mu_d;
      fire_q  <= fire_d;
    end
  end
endmodule

// File: rtl/fse_eq_fir.sv
// Parallel multiply-accumulate over the snapshot window, scaled and saturated.
module fse_eq_fir #(
  parameter int NTAPS = 25,
  parameter int XW    = 7,
  parameter int CW    = 10,
  parameter int AW    = 12
) (
  input  logic signed [XW-1:0] win  [NTAPS],
  input  logic signed [CW-1:0] coef [NTAPS],
  output logic signed [AW-1:0] y
);
  localparam int FRAC = CW - 2;
  localparam int PW   = XW + CW;
  localparam int SW   = PW + $clog2(NTAPS) + 1;
  localparam logic signed [SW-1:0] YMAX = SW'((1 << (AW-1)) - 1);
  localparam logic signed [SW-1:0] YMIN = -SW'(1 << (AW-1));

  logic signed [PW-1:0] prod [NTAPS];
  logic signed [SW-1:0] acc, scaled;

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    assign prod[k] = win[k] * coef[k];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++)
      acc = acc + {{(SW-PW){prod[k][PW-1]}}, prod[k]};
    scaled = acc >>> FRAC;
    if (scaled > YMAX)      y = YMAX[AW-1:0];
    else if (scaled < YMIN) y = YMIN[AW-1:0];
    else                    y = scaled[AW-1:0];
  end
endmodule

// File: rtl/fse_eq_slicer.sv
// Nearest-level decision over evenly spaced PAM levels.
module fse_eq_slicer
  import fse_eq_pkg::*;
#(
  parameter int AW   = 12,
  parameter int HALF = 8
) (
  input  logic signed [AW-1:0] y,
  output pam_sym_t             sym
);
  localparam int OFS   = PAM_LEVELS * HALF;
  localparam int SHIFT = $clog2(2 * HALF);

  logic signed [AW:0] biased, idx;

  always_comb begin
    biased = {y[AW-1], y} + (AW+1)'(OFS);
    idx    = biased >>> SHIFT;
    if (idx < 0)                               sym = '0;
    else if (idx > (AW+1)'(PAM_LEVELS - 1))    sym = pam_sym_t'(PAM_LEVELS - 1);
    else                                       sym = idx[PAM_BITS-1:0];
  end
endmodule

// File: rtl/fse_eq_coef_bank.sv
// Tap weights with gradient step, power-of-two gain and saturation.
module fse_eq_coef_bank #(
  parameter int NTAPS   = 25,
  parameter int XW      = 7,
  parameter int CW      = 10,
  parameter int AW      = 12,
  parameter int MUW     = 2,
  parameter int MU_BASE = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [AW-1:0] err,
  input  logic [MUW-1:0]       mu,
  input  logic signed [XW-1:0] win  [NTAPS],
  output logic signed [CW-1:0] coef [NTAPS]
);
  localparam int CENTER = NTAPS / 2;
  localparam int EW     = AW + XW;
  localparam logic signed [CW-1:0] UNITY = CW'(1 << (CW-2));
  localparam logic signed [EW:0]   CMAX  = (EW+1)'((1 << (CW-1)) - 1);
  localparam logic signed [EW:0]   CMIN  = -(EW+1)'(1 << (CW-1));

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [EW-1:0] grad, step;
    logic signed [EW:0]   sum;
    logic signed [CW-1:0] c_q, c_d;

    assign grad = err * win[k];
    assign step = grad >>> (MU_BASE + int'(mu));

    always_comb begin
      sum = {{(EW+1-CW){c_q[CW-1]}}, c_q} + {step[EW-1], step};
      c_d = c_q;
      if (upd) begin
        if (sum > CMAX)      c_d = CMAX[CW-1:0];
        else if (sum < CMIN) c_d = CMIN[CW-1:0];
        else                 c_d = sum[CW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= (k == CENTER) ? UNITY : '0;
      else        c_q <= c_d;
    end

    assign coef[k] = c_q;
  end
endmodule

// File: rtl/fse_lms_equalizer.sv
// Top: reset release, tap line, filter, slicer, error select, weight bank.
module fse_lms_equalizer
  import fse_eq_pkg::*;
#(
  parameter int NTAPS   = 25,
  parameter int XW      = 7,
  parameter int CW      = 10,
  parameter int AW      = 12,
  parameter int MUW     = 2,
  parameter int MU_BASE = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] smp_in,
  input  logic                 smp_valid,
  input  logic [PAM_BITS-1:0]  ref_sym,
  input  logic                 train_en,
  input  logic [MUW-1:0]       mu_sel,
  output logic signed [AW-1:0] eq_out,
  output logic [PAM_BITS-1:0]  dec_sym,
  output logic                 out_valid
);
  localparam int HALF = (1 << (XW-1)) / PAM_LEVELS;
  localparam int EMAX = (1 << (AW-1)) - 1;
  localparam int EMIN = -(1 << (AW-1));

  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic signed [XW-1:0] win  [NTAPS];
  logic signed [CW-1:0] coef [NTAPS];
  pam_sym_t             ref_q, sym;
  logic                 train_q, fire;
  logic [MUW-1:0]       mu_q;
  logic signed [AW-1:0] y, err;

  fse_eq_tapline #(.NTAPS(NTAPS), .XW(XW), .MUW(MUW)) u_line (
    .clk(clk), .rst_n(rst_i), .smp_in(smp_in), .smp_valid(smp_valid),
    .ref_sym(ref_sym), .train_en(train_en), .mu_sel(mu_sel),
    .win_q(win), .ref_q(ref_q), .train_q(train_q), .mu_q(mu_q), .fire_q(fire)
  );

  fse_eq_fir #(.NTAPS(NTAPS), .XW(XW), .CW(CW), .AW(AW)) u_fir (
    .win(win), .coef(coef), .y(y)
  );

  fse_eq_slicer #(.AW(AW), .HALF(HALF)) u_slice (
    .y(y), .sym(sym)
  );

  // Error against reference (training) or own decision.
  always_comb begin
    int tgt_lvl, diff;
    tgt_lvl = 2 * HALF * int'(train_q ? ref_q : sym) - (PAM_LEVELS - 1) * HALF;
    diff    = tgt_lvl - int'(y);
    if (diff > EMAX)      err = AW'(EMAX);
    else if (diff < EMIN) err = AW'(EMIN);
    else                  err = diff[AW-1:0];
  end

  fse_eq_coef_bank #(.NTAPS(NTAPS), .XW(XW), .CW(CW), .AW(AW),
                     .MUW(MUW), .MU_BASE(MU_BASE)) u_coef (
    .clk(clk), .rst_n(rst_i), .upd(fire), .err(err), .mu(mu_q),
    .win(win), .coef(coef)
  );

  logic signed [AW-1:0] eq_d;
  pam_sym_t             sym_d;

  always_comb begin
    eq_d  = fire ? y   : eq_out;
    sym_d = fire ? sym : dec_sym;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      eq_out    <= '0;
      dec_sym   <= '0;
      out_valid <= 1'b0;
    end else begin
      eq_out    <= eq_d;
      dec_sym   <= sym_d;
      out_valid <= fire;
    end
  end
endmodule

// File: rtl/fse_lms_equalizer_chk.sv
module fse_lms_equalizer_chk #(
  parameter int AW   = 12,
  parameter int HALF = 8,
  parameter int NLEV = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 out_valid,
  input logic signed [AW-1:0] eq_out,
  input logic [2:0]           dec_sym
);
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid, 2));

  assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(eq_out) && $stable(dec_sym)));

  assert_slice_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dec_sym != 3'd0) |->
      (int'(eq_out) >= 2 * HALF * int'(dec_sym) - NLEV * HALF));

  assert_slice_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dec_sym != 3'(NLEV - 1)) |->
      (int'(eq_out) < 2 * HALF * int'(dec_sym) - NLEV * HALF + 2 * HALF));
endmodule

bind fse_lms_equalizer fse_lms_equalizer_chk #(.AW(AW), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .out_valid(out_valid),
  .eq_out(eq_out), .dec_sym(dec_sym)
);

// File: tb/fse_lms_equalizer_test.sv
`timescale 1ns/1ps
module fse_lms_equalizer_test;
  localparam int NTAPS = 25;
  localparam int XW = 7, CW = 10, AW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic signed [XW-1:0] smp_in;
  logic smp_valid;
  logic [2:0] ref_sym;
  logic train_en;
  logic [1:0] mu_sel;
  logic signed [AW-1:0] eq_out;
  logic [2:0] dec_sym;
  logic out_valid;

  always #10 clk = ~clk;

  fse_lms_equalizer uut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_valid(smp_valid),
    .ref_sym(ref_sym), .train_en(train_en), .mu_sel(mu_sel),
    .eq_out(eq_out), .dec_sym(dec_sym), .out_valid(out_valid)
  );

  int tests = 0, fails = 0;
  bit done = 0, mon_en = 0;
  int n_exp = 0, n_got = 0;
  bit saw_top = 0, saw_bot = 0;

  typedef struct { int y; int s; string tag; } exp_t;
  exp_t sb[$];

  int mw [NTAPS];
  int mc [NTAPS];
  bit mph = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // Reference model built from R3..R9.
  task automatic model(int x, int r, bit t, int m, string tag);
    for (int k = NTAPS-1; k > 0; k--) mw[k] = mw[k-1];
    mw[0] = x;
    if (mph) begin
      longint acc = 0;
      int y, s, tg, e;
      exp_t it;
      for (int k = 0; k < NTAPS; k++) acc += longint'(mc[k]) * mw[k];
      y  = clampi(int'(acc >>> (CW-2)), -2048, 2047);
      s  = clampi((y + 64) >>> 4, 0, 7);
      tg = t ? r : s;
      e  = clampi(16*tg - 56 - y, -2048, 2047);
      for (int k = 0; k < NTAPS; k++)
        mc[k] = clampi(mc[k] + ((e * mw[k]) >>> (6 + m)), -512, 511);
      it.y = y; it.s = s; it.tag = tag;
      sb.push_back(it);
      n_exp++;
    end
    mph = ~mph;
  endtask

  task automatic put(int x, int r, bit t, int m, int gap, string tag);
    @(negedge clk);
    smp_in = x[XW-1:0]; smp_valid = 1'b1;
    ref_sym = r[2:0]; train_en = t; mu_sel = m[1:0];
    model(x, r, t, m, tag);
    repeat (gap) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_in = XW'($urandom); ref_sym = 3'($urandom);
      train_en = 1'($urandom); mu_sel = 2'($urandom);
    end
  endtask

  // First sample carries junk control (R5: ignored), second completes.
  task automatic symbol(int x0, int x1, int r, bit t, int m, int gap, string tag);
    put(x0, int'($urandom % 8), bit'($urandom), int'($urandom % 4), gap, tag);
    put(x1, r, t, m, gap, tag);
  endtask

  function automatic int pam(int s, int noise);
    return clampi(16*s - 56 + noise, -64, 63);
  endfunction

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      n_got++;
      if (sb.size() == 0) begin
        chk(0, "R2", "unexpected strobe", 1, 0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        chk(int'(eq_out) == it.y, it.tag, "eq_out", int'(eq_out), it.y);
        chk(int'(dec_sym) == it.s, "R4", "dec_sym", int'(dec_sym), it.s);
        if (it.tag == "R9") begin
          if (int'(eq_out) == 2047)  saw_top = 1;
          if (int'(eq_out) == -2048) saw_bot = 1;
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      chk(0, "R2", "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int prev;
    for (int k = 0; k < NTAPS; k++) begin mw[k] = 0; mc[k] = (k == NTAPS/2) ? 256 : 0; end
    rst_n = 1'b0; smp_in = '0; smp_valid = 1'b0; ref_sym = '0; train_en = 1'b0; mu_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(eq_out == '0, "R1", "eq_out", int'(eq_out), 0);
    chk(dec_sym == '0, "R1", "dec_sym", int'(dec_sym), 0);
    mon_en = 1;

    // R1/R3: first symbols expose the unity middle tap.
    prev = 3;
    for (int i = 0; i < 8; i++) begin
      int s = int'($urandom % 8);
      symbol(pam(prev, 0), pam(s, 0), s, 1'b1, 3, 1, "R1");
      prev = s;
    end
    // R5: training with noise, random gaps.
    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % 8);
      int nz = int'($urandom % 7) - 3;
      symbol((pam(prev, nz) + pam(s, -nz)) / 2, pam(s, nz), s, 1'b1, 2,
             int'($urandom % 3), "R5");
      prev = s;
    end
    // R6/R7: decision-directed, step sizes alternate.
    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % 8);
      int nz = int'($urandom % 5) - 2;
      symbol(pam(s, -nz), pam(s, nz), int'($urandom % 8), 1'b0,
             (i % 2) ? 3 : 1, int'($urandom % 2), (i % 2) ? "R6" : "R7");
    end
    // R3: back-to-back samples every cycle.
    for (int i = 0; i < 24; i++) begin
      int s = int'($urandom % 8);
      symbol(pam(prev, 1), pam(s, -1), s, 1'b1, 1, 0, "R3");
      prev = s;
    end
    // R8/R9: full-scale input with large error drives rails.
    for (int i = 0; i < 14; i++)
      symbol(-64, -64, 7, 1'b1, 0, 1, (i < 3) ? "R8" : "R9");
    @(negedge clk); smp_valid = 1'b0;
    repeat (8) @(negedge clk);

    chk(sb.size() == 0, "R2", "pending results", sb.size(), 0);
    chk(n_got == n_exp, "R2", "result count", n_got, n_exp);
    chk(saw_top, "R9", "upper rail seen", int'(saw_top), 1);
    chk(saw_bot, "R9", "lower rail seen", int'(saw_bot), 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule